// File: doc/BRIEF.md
# Two-Bit Mealy Sequence Machine

This block is a small clocked state machine with two state flip-flops and one serial input bit. The state changes only on the rising clock edge, and fixed next-state equations choose the new state. The single output bit is a Mealy output: it is computed combinationally from the present state and the present input bit. It can therefore change within a clock cycle when the input changes, with no edge needed.

The machine parks in the zero state whenever the input is low. A run of high inputs walks it from zero through one, then three, and then it settles in two. The output reports that a run of ones has just ended: it is high while the input is low and the state is non-zero. A synchronous active-high reset returns the machine to zero. The present state is visible on an observation port, so a system can trace the walk.

Top module: `tbit_mealy`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `state_o` becomes 2'b00 after that edge. `state_o[1]` is the upper state bit and `state_o[0]` is the lower state bit.
- R2: With `rst` low and `din` low at a rising edge, the state becomes 2'b00 from any of the four states.
- R3: With `rst` low, state 2'b00 and `din` high at a rising edge, the state becomes 2'b01.
- R4: With `rst` low, state 2'b01 and `din` high at a rising edge, the state becomes 2'b11.
- R5: With `rst` low, state 2'b10 or 2'b11 and `din` high at a rising edge, the state becomes 2'b10.
- R6: When `din` is low and the present state is non-zero, `dout` is 1 in the same cycle, with no clock edge needed. When `din` is low and the state is 2'b00, `dout` is 0.
- R7: Whenever `din` is high, `dout` is 0, whatever the state.
- R8: Reset wins over the input. With `rst` and `din` both high at an edge, the state still becomes 2'b00. This holds even from state 2'b01, which would otherwise step to 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial input bit |
| dout | output | 1 | Mealy output from state and `din` |
| state_o | output | 2 | Present state, upper bit in [1] |

## Verification
Two things can land in the same cycle. One is a reset. The other is a step that `din` = 1 would otherwise take, most sharply the step from 2'b01 to 2'b11. The bench first walks the machine into 2'b01, then raises `rst` and `din` together, and it expects 2'b00 after that edge. The second overlap is the Mealy output and the state update sharing a cycle. The bench changes `din` halfway through a cycle, samples `dout` before the edge against the present state, and samples `state_o` after the edge against the table row. A design that registered the output, or computed it from the next state, would then show the wrong value.

// File: rtl/tbit_mealy_pkg.sv
package tbit_mealy_pkg;

    // Encoded state: hi is the upper bit, lo the lower bit.
    typedef struct packed {
        logic hi;
        logic lo;
    } mst_t;

    localparam int unsigned ST_W = $bits(mst_t);
    localparam mst_t        ST_IDLE = '{hi: 1'b0, lo: 1'b0};

endpackage

// File: rtl/tbit_mealy_next.sv
module tbit_mealy_next
    import tbit_mealy_pkg::*;
(
    input  mst_t cur,
    input  logic din,
    output mst_t nxt
);

    always_comb begin
        nxt    = ST_IDLE;
        nxt.hi = (cur.hi & din) | (cur.lo & din);
        nxt.lo = (~cur.hi) & din;
    end

endmodule

// File: rtl/tbit_mealy_out.sv
module tbit_mealy_out
    import tbit_mealy_pkg::*;
(
    input  mst_t cur,
    input  logic din,
    output logic dout
);

    always_comb begin
        dout = (cur.hi | cur.lo) & ~din;
    end

endmodule

// File: rtl/tbit_mealy.sv
module tbit_mealy
    import tbit_mealy_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                din,
    output logic                dout,
    output logic [ST_W-1:0]     state_o
);

    typedef struct packed {
        mst_t st;
    } regs_t;

    regs_t r_d;
    regs_t r_q;
    mst_t  step;

    tbit_mealy_next u_next (
        .cur (r_q.st),
        .din (din),
        .nxt (step)
    );

    tbit_mealy_out u_out (
        .cur  (r_q.st),
        .din  (din),
        .dout (dout)
    );

    always_comb begin
        r_d    = r_q;
        r_d.st = step;
        if (rst) begin
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state_o = r_q.st;

endmodule

// File: rtl/tbit_mealy_chk.sv
module tbit_mealy_chk (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       dout,
    input logic [1:0] state_o
);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1: a registered reset leaves the state at zero.
    always @(negedge clk) begin
        if (rst_seen_q === 1'b1) begin
            p_reset_zero_r1: assert (state_o == 2'b00)
                else $error("reset did not clear state");
        end
    end

    p_low_clears_r2: assert property (@(posedge clk) disable iff (rst)
        !din |=> state_o == 2'b00);

    p_idle_step_r3: assert property (@(posedge clk) disable iff (rst)
        (din && state_o == 2'b00) |=> state_o == 2'b01);

    p_one_step_r4: assert property (@(posedge clk) disable iff (rst)
        (din && state_o == 2'b01) |=> state_o == 2'b11);

    p_upper_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (din && state_o[1]) |=> state_o == 2'b10);

    p_out_high_r6: assert property (@(posedge clk) disable iff (rst)
        (!din && state_o != 2'b00) |-> dout);

    p_out_low_r7: assert property (@(posedge clk) disable iff (rst)
        din |-> !dout);

endmodule

bind tbit_mealy tbit_mealy_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .dout    (dout),
    .state_o (state_o)
);

// File: tb/tbit_mealy_tb.sv
`timescale 1ns/1ps
module tbit_mealy_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       dout;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tbit_mealy u_dut (
        .clk     (clk),
        .rst     (rst),
        .din     (din),
        .dout    (dout),
        .state_o (state_o)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Bring the machine to state s using only reset and ones.
    task automatic go_to(input logic [1:0] s);
        int n;
        n = (s == 2'b00) ? 0 : (s == 2'b01) ? 1 : (s == 2'b11) ? 2 : 3;
        @(negedge clk); rst = 1'b1; din = 1'b0;
        @(posedge clk);
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < n; i++) begin
            din = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        din = 1'b0;
    endtask

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic x);
        if (!x) return 2'b00;
        case (s)
            2'b00:   return 2'b01;
            2'b01:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    // Apply one table row; checks output mid-cycle and state after the edge.
    task automatic row(input string req_s, input string req_y, input logic [1:0] s, input logic x);
        go_to(s);
        chk("walk", state_o, s);
        din = x;
        #1;
        chk(req_y, {1'b0, dout}, {1'b0, (s != 2'b00) && !x});
        @(posedge clk); #1;
        chk(req_s, state_o, ref_next(s, x));
    endtask

    task automatic t_reset_state();
        @(negedge clk); rst = 1'b1; din = 1'b0;
        @(posedge clk); #1;
        chk("R1", state_o, 2'b00);
        chk("R1 dout", {1'b0, dout}, 2'b00);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_zero_input();
        for (int s = 0; s < 4; s++) row("R2", "R6", 2'(s), 1'b0);
    endtask

    task automatic t_from_idle();
        row("R3", "R7", 2'b00, 1'b1);
    endtask

    task automatic t_from_one();
        row("R4", "R7", 2'b01, 1'b1);
    endtask

    task automatic t_from_upper();
        row("R5", "R7", 2'b10, 1'b1);
        row("R5", "R7", 2'b11, 1'b1);
    endtask

    // Output follows din inside one cycle without a clock edge.
    task automatic t_output_mid_cycle();
        go_to(2'b11);
        din = 1'b1; #0.5;
        chk("R7", {1'b0, dout}, 2'b00);
        din = 1'b0; #0.5;
        chk("R6", {1'b0, dout}, 2'b01);
    endtask

    task automatic t_reset_priority();
        go_to(2'b01);
        rst = 1'b1; din = 1'b1;
        @(posedge clk); #1;
        chk("R8", state_o, 2'b00);
        chk("R8 dout", {1'b0, dout}, 2'b00);
        @(negedge clk); rst = 1'b0; din = 1'b0;
    endtask

    initial begin
        t_reset_state();
        t_zero_input();
        t_from_idle();
        t_from_one();
        t_from_upper();
        t_output_mid_cycle();
        t_reset_priority();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule